// File: doc/BRIEF.md
# SPI Camera Frame Capture Sequencer

This block is an SPI master that takes an image sensor module through one complete frame capture. A one-cycle pulse on `start` begins the sequence, which runs three phases in a fixed order.

First it writes a short list of register settings. The list is generated at elaboration. Next it reads the sensor's status register repeatedly until a chosen ready bit reads as one. Last it opens a single burst-read transaction and streams every image byte out of the block, one byte per valid strobe.

A downstream pixel pipeline takes the bytes as they arrive. It runs at the pace set by the SPI clock and has no backpressure. When the last byte of the frame has been delivered, the block pulses `frame_done` and returns to idle.

Top module: `camseq_top`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0, and `byte_valid` and `frame_done` are 0. No SPI transaction starts until `start` is seen high.
- R2: SPI mode 0 is used. `sck` idles low and every high level of `sck` lasts exactly `CLK_DIV` system cycles. `mosi` changes only while `sck` is low and carries each byte MSB first. `miso` is sampled on the rising edge of `sck`.
- R3: The capture phase makes `N_CMDS` separate transactions, in index order i = 0, 1, and so on. Each transaction is exactly two bytes. The first byte is 0x80 OR (`CMD_BASE` + i), so its MSB marks a write. The second byte is (`VAL_MUL`*i + `VAL_OFS`) mod 256.
- R4: The wait phase makes two-byte status reads. Each sends `STATUS_ADDR` with MSB 0, then 0x00, and takes the second received byte as the status. It makes at least one read. It keeps polling while status bit `FLAG_BIT` is 0, whatever the other bits hold, and stops after the first read that shows the bit as 1.
- R5: After the ready bit is seen, the block makes exactly one burst transaction. It sends `BURST_CMD` and then receives `FRAME_BYTES` bytes while `cs_n` stays low throughout.
- R6: Each byte received in the burst appears on `byte_data`, in arrival order, with `byte_valid` high for exactly one system cycle.
- R7: Exactly `FRAME_BYTES` bytes are delivered per frame. `frame_done` is a one-cycle pulse in the same cycle as the final `byte_valid`, and `cs_n` is 1 in the following cycle.
- R8: `start` has no effect while a capture is in progress. After `frame_done` the block stays idle with `cs_n` high until the next `start`.
- R9: Between two transactions of one frame, `cs_n` stays high for exactly `CS_GAP` system cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins one frame capture when idle |
| miso | input | 1 | Serial data from the sensor module |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | Serial data to the sensor module |
| byte_data | output | 8 | Received image byte |
| byte_valid | output | 1 | `byte_data` holds a new image byte this cycle |
| frame_done | output | 1 | Final byte of the frame delivered this cycle |

## Verification
The bench builds the block with `CLK_DIV` = 2, three capture commands from base register 5, a six-byte frame, `CS_GAP` = 3, status register 0x41 and ready bit 3. With these values a whole frame takes under a thousand cycles. That makes it practical to sweep the number of not-ready status replies from zero to three, and to vary the image pattern on every frame. Every not-ready reply has all bits other than the ready bit set, so sampling the wrong bit position causes a visible early burst. One frame also receives a second `start` during the command phase.

// File: rtl/camseq_pkg.sv
package camseq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_GAP,
      SEQ_XFER
   } seq_state_t;

   typedef enum logic [1:0] {
      PH_CMD,
      PH_POLL,
      PH_BURST
   } phase_t;

   localparam logic WR_MARK = 1'b1;
   localparam logic RD_MARK = 1'b0;
   localparam logic [7:0] FILL_BYTE = 8'h00;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/camseq_tick.sv
module camseq_tick #(
   parameter int unsigned DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   localparam int unsigned CW = camseq_pkg::idx_width(DIV);

   logic [CW-1:0] cnt_q;

   assign tick = en && (cnt_q == CW'(DIV - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (en) begin
         cnt_q <= tick ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/camseq_shifter.sv
module camseq_shifter #(
   parameter int unsigned CLK_DIV = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       done,
   output logic [7:0] rx_byte
);
   logic       active_q;
   logic       tick;
   logic [7:0] tx_q;
   logic [7:0] rx_q;
   logic [2:0] bit_q;

   camseq_tick #(.DIV(CLK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (load),
      .en   (active_q),
      .tick (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sck      <= 1'b0;
         mosi     <= 1'b0;
         done     <= 1'b0;
         tx_q     <= '0;
         rx_q     <= '0;
         bit_q    <= '0;
      end else begin
         done <= 1'b0;
         if (load) begin
            active_q <= 1'b1;
            sck      <= 1'b0;
            mosi     <= tx_byte[7];
            tx_q     <= {tx_byte[6:0], 1'b0};
            bit_q    <= '0;
         end else if (active_q && tick) begin
            if (!sck) begin
               sck  <= 1'b1;
               rx_q <= {rx_q[6:0], miso};
            end else begin
               sck <= 1'b0;
               if (bit_q == 3'd7) begin
                  active_q <= 1'b0;
                  done     <= 1'b1;
               end else begin
                  bit_q <= bit_q + 3'd1;
                  mosi  <= tx_q[7];
                  tx_q  <= {tx_q[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign rx_byte = rx_q;
endmodule

// File: rtl/camseq_cmd_rom.sv
module camseq_cmd_rom #(
   parameter int unsigned N_CMDS   = 4,
   parameter int unsigned CMD_BASE = 1,
   parameter int unsigned VAL_MUL  = 37,
   parameter int unsigned VAL_OFS  = 1,
   parameter int unsigned IDXW     = 2
) (
   input  logic [IDXW-1:0] idx,
   output logic [6:0]      reg_addr,
   output logic [7:0]      reg_val
);
   logic [6:0] addr_tbl [N_CMDS];
   logic [7:0] val_tbl  [N_CMDS];

   for (genvar i = 0; i < N_CMDS; i++) begin : g_ent
      assign addr_tbl[i] = 7'((CMD_BASE + i) % 128);
      assign val_tbl[i]  = 8'((VAL_MUL * i + VAL_OFS) % 256);
   end

   always_comb begin
      reg_addr = '0;
      reg_val  = '0;
      for (int k = 0; k < N_CMDS; k++) begin
         if (int'(idx) == k) begin
            reg_addr = addr_tbl[k];
            reg_val  = val_tbl[k];
         end
      end
   end
endmodule

// File: rtl/camseq_top.sv
module camseq_top #(
   parameter int unsigned CLK_DIV     = 8,
   parameter int unsigned N_CMDS      = 4,
   parameter int unsigned CMD_BASE    = 1,
   parameter int unsigned VAL_MUL     = 37,
   parameter int unsigned VAL_OFS     = 1,
   parameter logic [6:0]  STATUS_ADDR = 7'h41,
   parameter int unsigned FLAG_BIT    = 3,
   parameter logic [7:0]  BURST_CMD   = 8'h3C,
   parameter int unsigned FRAME_BYTES = 153600,
   parameter int unsigned CS_GAP      = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       miso,
   output logic       cs_n,
   output logic       sck,
   output logic       mosi,
   output logic [7:0] byte_data,
   output logic       byte_valid,
   output logic       frame_done
);
   import camseq_pkg::*;

   localparam int unsigned IDXW = idx_width(N_CMDS);
   localparam int unsigned GW   = idx_width(CS_GAP);
   localparam int unsigned RCW  = idx_width(FRAME_BYTES);

   if (CLK_DIV < 1) begin : g_bad_div
      $error("camseq_top: CLK_DIV must be at least 1");
   end
   if (N_CMDS < 1) begin : g_bad_cmds
      $error("camseq_top: N_CMDS must be at least 1");
   end
   if (CMD_BASE + N_CMDS > 128) begin : g_bad_base
      $error("camseq_top: command registers exceed 7-bit address space");
   end
   if (FLAG_BIT > 7) begin : g_bad_flag
      $error("camseq_top: FLAG_BIT must lie within a byte");
   end
   if (FRAME_BYTES < 1) begin : g_bad_frame
      $error("camseq_top: FRAME_BYTES must be at least 1");
   end
   if (CS_GAP < 1) begin : g_bad_gap
      $error("camseq_top: CS_GAP must be at least 1");
   end

   seq_state_t     state_q;
   phase_t         phase_q;
   logic           cs_n_q;
   logic [IDXW-1:0] cmd_idx_q;
   logic [GW-1:0]  gap_q;
   logic           second_q;
   logic [RCW-1:0] rd_cnt_q;
   logic [7:0]     data_q;
   logic           valid_q;
   logic           done_q;

   logic           sh_load;
   logic [7:0]     sh_tx;
   logic           sh_done;
   logic [7:0]     sh_rx;
   logic [6:0]     rom_addr;
   logic [7:0]     rom_val;

   logic           gap_end;
   logic           last_rd;
   logic [7:0]     opener;

   camseq_cmd_rom #(
      .N_CMDS  (N_CMDS),
      .CMD_BASE(CMD_BASE),
      .VAL_MUL (VAL_MUL),
      .VAL_OFS (VAL_OFS),
      .IDXW    (IDXW)
   ) u_rom (
      .idx     (cmd_idx_q),
      .reg_addr(rom_addr),
      .reg_val (rom_val)
   );

   camseq_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (sh_load),
      .tx_byte(sh_tx),
      .miso   (miso),
      .sck    (sck),
      .mosi   (mosi),
      .done   (sh_done),
      .rx_byte(sh_rx)
   );

   assign gap_end = (state_q == SEQ_GAP) && (gap_q == GW'(CS_GAP - 1));
   assign last_rd = (rd_cnt_q == RCW'(FRAME_BYTES - 1));

   always_comb begin
      unique case (phase_q)
         PH_CMD:  opener = {WR_MARK, rom_addr};
         PH_POLL: opener = {RD_MARK, STATUS_ADDR};
         default: opener = BURST_CMD;
      endcase
   end

   always_comb begin
      sh_load = 1'b0;
      sh_tx   = FILL_BYTE;
      if (gap_end) begin
         sh_load = 1'b1;
         sh_tx   = opener;
      end else if (state_q == SEQ_XFER && sh_done) begin
         if (!second_q) begin
            sh_load = 1'b1;
            sh_tx   = (phase_q == PH_CMD) ? rom_val : FILL_BYTE;
         end else if (phase_q == PH_BURST && !last_rd) begin
            sh_load = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         phase_q   <= PH_CMD;
         cs_n_q    <= 1'b1;
         cmd_idx_q <= '0;
         gap_q     <= '0;
         second_q  <= 1'b0;
         rd_cnt_q  <= '0;
         data_q    <= '0;
         valid_q   <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         done_q  <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q   <= SEQ_GAP;
                  phase_q   <= PH_CMD;
                  gap_q     <= '0;
                  cmd_idx_q <= '0;
                  rd_cnt_q  <= '0;
               end
            end
            SEQ_GAP: begin
               gap_q <= gap_q + 1'b1;
               if (gap_end) begin
                  state_q  <= SEQ_XFER;
                  cs_n_q   <= 1'b0;
                  second_q <= 1'b0;
               end
            end
            default: begin
               if (sh_done) begin
                  if (!second_q) begin
                     second_q <= 1'b1;
                  end else begin
                     unique case (phase_q)
                        PH_CMD: begin
                           cs_n_q  <= 1'b1;
                           state_q <= SEQ_GAP;
                           gap_q   <= '0;
                           if (cmd_idx_q == IDXW'(N_CMDS - 1)) begin
                              phase_q <= PH_POLL;
                           end else begin
                              cmd_idx_q <= cmd_idx_q + 1'b1;
                           end
                        end
                        PH_POLL: begin
                           cs_n_q  <= 1'b1;
                           state_q <= SEQ_GAP;
                           gap_q   <= '0;
                           if (sh_rx[FLAG_BIT]) begin
                              phase_q <= PH_BURST;
                           end
                        end
                        default: begin
                           valid_q <= 1'b1;
                           data_q  <= sh_rx;
                           if (last_rd) begin
                              done_q  <= 1'b1;
                              cs_n_q  <= 1'b1;
                              state_q <= SEQ_IDLE;
                           end else begin
                              rd_cnt_q <= rd_cnt_q + 1'b1;
                           end
                        end
                     endcase
                  end
               end
            end
         endcase
      end
   end

   assign cs_n       = cs_n_q;
   assign byte_data  = data_q;
   assign byte_valid = valid_q;
   assign frame_done = done_q;
endmodule

// File: rtl/camseq_chk.sv
module camseq_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sck,
   input logic mosi,
   input logic byte_valid,
   input logic frame_done
);
   // R7
   done_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> byte_valid);

   // R7
   release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> cs_n);

   // R6
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid);

   // R2
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   // R2
   mosi_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && (mosi != $past(mosi))) |-> !sck);

   // R5
   burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && !frame_done) |-> !cs_n);
endmodule

bind camseq_top camseq_chk u_chk (.*);

// File: tb/camseq_top_test.sv
`timescale 1ns/1ps
module camseq_top_test;
   localparam int          DIV   = 2;
   localparam int          NCMD  = 3;
   localparam int          BASE  = 5;
   localparam logic [6:0]  STAT  = 7'h41;
   localparam int          FLAG  = 3;
   localparam logic [7:0]  BURST = 8'h3C;
   localparam int          FRAME = 6;
   localparam int          GAP   = 3;

   logic clk = 1'b0;
   logic rst_n, start, miso;
   logic cs_n, sck, mosi, byte_valid, frame_done;
   logic [7:0] byte_data;

   always #2.5 clk = ~clk;

   camseq_top #(
      .CLK_DIV(DIV), .N_CMDS(NCMD), .CMD_BASE(BASE), .VAL_MUL(37), .VAL_OFS(1),
      .STATUS_ADDR(STAT), .FLAG_BIT(FLAG), .BURST_CMD(BURST),
      .FRAME_BYTES(FRAME), .CS_GAP(GAP)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .miso(miso),
      .cs_n(cs_n), .sck(sck), .mosi(mosi),
      .byte_data(byte_data), .byte_valid(byte_valid), .frame_done(frame_done)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   int frame_no = 0;
   int ready_after = 0;

   // sensor model
   logic [7:0] tr_b [0:127][0:15];
   int tr_len [0:127];
   int tr_n = 0;
   logic miso_r = 1'b0;
   int bitpos = 0, bytepos = 0, polls = 0, seen_frame = -1;
   logic [7:0] sh = 8'h00, cmd = 8'h00;
   bit in_tr = 1'b0;

   assign miso = miso_r;

   function automatic logic [7:0] reply(input int bp);
      logic [7:0] r;
      r = 8'h00;
      if (bp >= 1 && cmd == {1'b0, STAT} && bp == 1)
         r = (polls >= ready_after) ? (8'h01 << FLAG) : ~(8'h01 << FLAG);
      else if (bp >= 1 && cmd == BURST)
         r = 8'((bp - 1) * 7 + 3 + 16 * frame_no);
      return r;
   endfunction

   always @(negedge cs_n) begin
      if (seen_frame != frame_no) begin
         polls = 0;
         seen_frame = frame_no;
      end
      in_tr = 1'b1; bitpos = 0; bytepos = 0; cmd = 8'h00; miso_r = 1'b0;
   end

   always @(posedge sck) begin
      if (in_tr && !cs_n) begin
         sh = {sh[6:0], mosi};
         bitpos++;
         if (bitpos == 8) begin
            if (tr_n < 128 && bytepos < 16) tr_b[tr_n][bytepos] = sh;
            if (bytepos == 0) cmd = sh;
            bytepos++;
            bitpos = 0;
         end
      end
   end

   always @(negedge sck) begin
      if (in_tr && !cs_n) begin
         logic [7:0] r;
         r = reply(bytepos);
         miso_r = r[7 - bitpos];
      end
   end

   always @(posedge cs_n) begin
      if (in_tr) begin
         in_tr = 1'b0;
         if (tr_n < 128) tr_len[tr_n] = bytepos;
         if (cmd == {1'b0, STAT}) polls++;
         tr_n++;
      end
   end

   // output and timing monitor
   logic [7:0] out_b [0:63];
   int out_n = 0, fd_n = 0, fd_idx = -1;
   int gaps [0:127];
   int g_n = 0, cs_hi = 0, sck_hi = 0, sck_bad = 0, sck_highs = 0, cs_after_bad = 0;
   logic prev_cs = 1'b1, prev_sck = 1'b0, prev_fd = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!cs_n && prev_cs) begin
            if (g_n < 128) gaps[g_n] = cs_hi;
            g_n++;
         end
         cs_hi = cs_n ? cs_hi + 1 : 0;
         if (!sck && prev_sck) begin
            sck_highs++;
            if (sck_hi != DIV) sck_bad++;
         end
         sck_hi = sck ? sck_hi + 1 : 0;
         if (prev_fd && !cs_n) cs_after_bad++;
         if (frame_done) begin
            fd_n++;
            fd_idx = out_n;
         end
         if (byte_valid) begin
            if (out_n < 64) out_b[out_n] = byte_data;
            out_n++;
         end
         prev_cs = cs_n; prev_sck = sck; prev_fd = frame_done;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_frame(input int fno, input int rdy, input bit extra);
      int tb, ob, fd0, tdone, p;
      tb = tr_n; ob = out_n; fd0 = fd_n;
      frame_no = fno; ready_after = rdy;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      if (extra) begin
         repeat (60) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      while (fd_n == fd0) @(negedge clk);
      tdone = tr_n;
      repeat (300) @(negedge clk);
      // R8: idle after the frame, no extra transactions
      chk("R8 idle transactions", tr_n, tdone);
      chk("R8 cs_n idle", int'(cs_n), 1);
      chk("R8 transaction count", tr_n - tb, NCMD + rdy + 2);
      // R3 command list
      for (int i = 0; i < NCMD; i++) begin
         chk("R3 cmd length", tr_len[tb + i], 2);
         chk("R3 cmd address", int'(tr_b[tb + i][0]), 128 + BASE + i);
         chk("R3 cmd value", int'(tr_b[tb + i][1]), (37 * i + 1) % 256);
      end
      // R4 polls
      for (int k = 0; k <= rdy; k++) begin
         p = tb + NCMD + k;
         chk("R4 poll length", tr_len[p], 2);
         chk("R4 poll address", int'(tr_b[p][0]), int'(STAT));
         chk("R4 poll filler", int'(tr_b[p][1]), 0);
      end
      // R5 burst
      p = tb + NCMD + rdy + 1;
      chk("R5 burst length", tr_len[p], FRAME + 1);
      chk("R5 burst command", int'(tr_b[p][0]), int'(BURST));
      // R6 data and R7 count / done placement
      chk("R7 byte count", out_n - ob, FRAME);
      for (int k = 0; k < FRAME; k++)
         chk("R6 image byte", int'(out_b[ob + k]), (k * 7 + 3 + 16 * fno) % 256);
      chk("R7 done pulses", fd_n - fd0, 1);
      chk("R7 done with last byte", fd_idx, ob + FRAME - 1);
      chk("R7 cs release", cs_after_bad, 0);
      // R9 chip-select gaps inside the frame
      for (int t = tb + 1; t < tr_n; t++)
         chk("R9 cs gap", gaps[t], GAP);
      // R2 sck high width
      chk("R2 sck high width", sck_bad, 0);
      chk("R2 sck toggled", int'(sck_highs > 0), 1);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cs_n", int'(cs_n), 1);
      chk("R1 sck", int'(sck), 0);
      chk("R1 byte_valid", int'(byte_valid), 0);
      chk("R1 frame_done", int'(frame_done), 0);
      repeat (50) @(negedge clk);
      chk("R1 no transaction before start", tr_n, 0);
      for (int f = 0; f < 4; f++) run_frame(f, f, 1'b0);
      run_frame(4, 2, 1'b1);
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule